// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block decodes each processor bus cycle against a set of programmable regions and drives one active-low select strobe per region. A region is described by a base word (the upper address bits of the region and a 3-bit size code) and an option word that narrows the match to particular byte lanes, a transfer direction, an address space and, for CPU-space cycles, an interrupt level. A per-channel role field decides whether the pin acts as a select at all, and whether the external device is an 8-bit or a 16-bit port.

Once a channel is selected, the block counts bus clocks and raises the data-size acknowledge matching the port width after the programmed number of wait states. Two wait codes are special: one terminates the cycle at once and the other leaves the acknowledge to an outside device. A CPU-space channel may also request an autovectored interrupt acknowledge. Configuration words are static inputs held by the surrounding register logic.

Top module: `csgen_top`

## Requirements
- R1: A channel matches only when address bits from the region size upward equal the base word bits [15:3] placed at address bits 23:11; base bits [2:0] code the size as 0:2K, 1:8K, 2:16K, 3:64K, 4:128K, 5:256K, 6:512K, 7:1M, and address bits below the size are ignored.
- R2: A channel whose role is 00 (discrete output) or 01 (alternate function), or whose lane field (option bits 14:13) is 00, never drives its select low.
- R3: Lane field 01 matches cycles using the lower byte, 10 the upper byte, 11 either; the lower and upper lane inputs give the lanes in use.
- R4: Direction field (option bits 12:11) 01 matches reads only, 10 writes only, 11 both, 00 neither; the read input is 1 for a read.
- R5: Space field (option bits 5:4) 00 matches CPU-space cycles, 01 user, 10 supervisor, 11 user or supervisor; cycle space input codes are 0 CPU, 1 user, 2 supervisor, and 3 matches nothing.
- R6: In a CPU-space cycle a nonzero level field (option bits 3:1) must equal the cycle's interrupt level; zero accepts any level.
- R7: Option bit 10 clear qualifies the match with the address strobe, set with the data strobe.
- R8: The select goes low in the cycle after a clock edge that samples a match and returns high in the cycle after an edge that samples none; after reset all selects are high and all acknowledges low.
- R9: Wait code n in 0..13 (option bits 9:6) raises the acknowledge in the (n+1)th cycle after the select first goes low and holds it while the match lasts.
- R10: Wait code 14 raises the acknowledge in the same cycle the select first goes low.
- R11: Wait code 15 never raises an acknowledge from the block.
- R12: A channel with role 10 drives the 8-bit acknowledge and one with role 11 the 16-bit acknowledge; several channels combine by OR.
- R13: The autovector output is high while a selected channel has space field 00 and option bit 0 set.
- R14: With option bit 15 set the select is low only in the first cycle of a match; the acknowledge timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Cycle address |
| cyc_space | input | 2 | Cycle space: 0 CPU, 1 user, 2 supervisor |
| rd | input | 1 | 1 read, 0 write |
| lane_lo | input | 1 | Lower byte lane in use |
| lane_hi | input | 1 | Upper byte lane in use |
| irq_lvl | input | 3 | Interrupt level of a CPU-space cycle |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe, active high |
| cfg_base | input | NUM_CS*16 | Base words, channel k at [16k+15:16k] |
| cfg_opt | input | NUM_CS*16 | Option words, channel k at [16k+15:16k] |
| cfg_role | input | NUM_CS*2 | Role fields, channel k at [2k+1:2k] |
| cs_n | output | NUM_CS | Active-low selects |
| ack8 | output | 1 | Acknowledge for an 8-bit port |
| ack16 | output | 1 | Acknowledge for a 16-bit port |
| avec | output | 1 | Autovector request |

## Verification
The bench builds the block with four channels, enough to hold a 16-bit and an 8-bit port, a fast-terminated and an externally acknowledged channel, and a CPU-space channel at once, so the OR of acknowledges and overlap-free decoding are both exercised. One channel is reprogrammed through all eight size codes and all fourteen counted wait codes, which puts the region edges at 2K through 1M and the longest wait of fourteen cycles within reach of ordinary bus cycles.

// File: rtl/csgen_pkg.sv
package csgen_pkg;

    localparam int ADDR_W       = 24;
    localparam int CFG_W        = 16;
    localparam int ROLE_W       = 2;
    localparam int MIN_BLK_LOG2 = 11;
    localparam int HI_W         = ADDR_W - MIN_BLK_LOG2;
    localparam int SIZE_W       = CFG_W - HI_W;
    localparam int WAIT_W       = 4;

    localparam logic [WAIT_W-1:0] WAIT_FAST = 4'd14;
    localparam logic [WAIT_W-1:0] WAIT_EXT  = 4'd15;

    typedef enum logic [1:0] {
        ROLE_DOUT = 2'b00,
        ROLE_ALT  = 2'b01,
        ROLE_CS8  = 2'b10,
        ROLE_CS16 = 2'b11
    } role_e;

    typedef enum logic [1:0] {
        SP_CPU   = 2'b00,
        SP_USER  = 2'b01,
        SP_SUPER = 2'b10,
        SP_ANY   = 2'b11
    } space_e;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [SIZE_W-1:0] size;
    } base_t;

    typedef struct packed {
        logic              pulse;
        logic [1:0]        lanes;
        logic [1:0]        dir;
        logic              on_ds;
        logic [WAIT_W-1:0] wcode;
        space_e            space;
        logic [2:0]        ipl;
        logic              avec;
    } opt_t;

    function automatic logic [4:0] blk_log2(input logic [SIZE_W-1:0] code);
        logic [4:0] r;
        case (code)
            3'd0:    r = 5'd11;
            3'd1:    r = 5'd13;
            3'd2:    r = 5'd14;
            default: r = 5'd13 + {2'b00, code};
        endcase
        return r;
    endfunction

    function automatic logic wait_done(input logic [WAIT_W-1:0] wcode,
                                       input logic [WAIT_W-1:0] cnt);
        logic r;
        if (wcode == WAIT_FAST)     r = 1'b1;
        else if (wcode == WAIT_EXT) r = 1'b0;
        else                        r = (cnt > wcode);
        return r;
    endfunction

endpackage

// File: rtl/csgen_match.sv
module csgen_match
    import csgen_pkg::*;
(
    input  base_t              base,
    input  opt_t               opt,
    input  role_e              role,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         cyc_space,
    input  logic               rd,
    input  logic               lane_lo,
    input  logic               lane_hi,
    input  logic [2:0]         irq_lvl,
    input  logic               as_i,
    input  logic               ds_i,
    output logic               hit
);
    logic [HI_W-1:0] cmp_mask;
    logic [4:0]      size_log2;
    logic            addr_ok, lane_ok, dir_ok, space_ok, ipl_ok, strobe_ok, role_ok;
    logic            cpu_cycle;

    assign size_log2 = blk_log2(base.size);

    // R1: keep address bits at or above the region size
    always_comb begin
        for (int i = 0; i < HI_W; i++) begin
            cmp_mask[i] = ((i + MIN_BLK_LOG2) >= int'(size_log2));
        end
    end

    assign addr_ok   = (((addr[ADDR_W-1:MIN_BLK_LOG2] ^ base.hi) & cmp_mask) == '0);
    assign lane_ok   = (opt.lanes[0] & lane_lo) | (opt.lanes[1] & lane_hi);
    assign dir_ok    = rd ? opt.dir[0] : opt.dir[1];
    assign cpu_cycle = (cyc_space == 2'd0);

    always_comb begin
        case (opt.space)
            SP_CPU:   space_ok = cpu_cycle;
            SP_USER:  space_ok = (cyc_space == 2'd1);
            SP_SUPER: space_ok = (cyc_space == 2'd2);
            default:  space_ok = (cyc_space == 2'd1) || (cyc_space == 2'd2);
        endcase
    end

    assign ipl_ok    = !cpu_cycle || (opt.ipl == 3'd0) || (opt.ipl == irq_lvl);
    assign strobe_ok = opt.on_ds ? ds_i : as_i;
    assign role_ok   = role[1];

    assign hit = addr_ok & lane_ok & dir_ok & space_ok & ipl_ok & strobe_ok & role_ok;

endmodule

// File: rtl/csgen_wait.sv
module csgen_wait
    import csgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              pulse,
    input  logic [WAIT_W-1:0] wcode,
    output logic              sel,
    output logic              first,
    output logic              ack
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            cnt <= '0;
        end else if (!hit) begin
            sel <= 1'b0;
            cnt <= '0;
        end else begin
            sel <= 1'b1;
            if (!sel)              cnt <= '0;
            else if (cnt != '1)    cnt <= cnt + 1'b1;
        end
    end

    assign first = sel && (cnt == '0);
    assign ack   = sel && wait_done(wcode, cnt);

    AST_FAST_ACK: assert property (@(posedge clk) disable iff (rst)
        (wcode == WAIT_FAST) && $rose(sel) |-> ack); // R10

    AST_COUNTED_WAIT: assert property (@(posedge clk) disable iff (rst)
        (wcode < WAIT_FAST) && $rose(sel) |-> !ack); // R9

    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ack && hit && $stable(wcode) |=> ack); // R9

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        pulse && sel && $past(sel) |-> !first); // R14

endmodule

// File: rtl/csgen_top.sv
module csgen_top
    import csgen_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [1:0]                cyc_space,
    input  logic                      rd,
    input  logic                      lane_lo,
    input  logic                      lane_hi,
    input  logic [2:0]                irq_lvl,
    input  logic                      as_i,
    input  logic                      ds_i,
    input  logic [NUM_CS*CFG_W-1:0]   cfg_base,
    input  logic [NUM_CS*CFG_W-1:0]   cfg_opt,
    input  logic [NUM_CS*ROLE_W-1:0]  cfg_role,
    output logic [NUM_CS-1:0]         cs_n,
    output logic                      ack8,
    output logic                      ack16,
    output logic                      avec
);
    logic [NUM_CS-1:0] ch_hit, ch_sel, ch_first, ch_ack, ch_w8, ch_w16, ch_av;

    for (genvar k = 0; k < NUM_CS; k++) begin : g_ch
        base_t base_k;
        opt_t  opt_k;
        role_e role_k;

        assign base_k = base_t'(cfg_base[k*CFG_W +: CFG_W]);
        assign opt_k  = opt_t'(cfg_opt[k*CFG_W +: CFG_W]);
        assign role_k = role_e'(cfg_role[k*ROLE_W +: ROLE_W]);

        csgen_match u_match (
            .base      (base_k),
            .opt       (opt_k),
            .role      (role_k),
            .addr      (addr),
            .cyc_space (cyc_space),
            .rd        (rd),
            .lane_lo   (lane_lo),
            .lane_hi   (lane_hi),
            .irq_lvl   (irq_lvl),
            .as_i      (as_i),
            .ds_i      (ds_i),
            .hit       (ch_hit[k])
        );

        csgen_wait u_wait (
            .clk   (clk),
            .rst   (rst),
            .hit   (ch_hit[k]),
            .pulse (opt_k.pulse),
            .wcode (opt_k.wcode),
            .sel   (ch_sel[k]),
            .first (ch_first[k]),
            .ack   (ch_ack[k])
        );

        assign cs_n[k]   = !(opt_k.pulse ? ch_first[k] : ch_sel[k]);
        assign ch_w8[k]  = ch_ack[k] && (role_k == ROLE_CS8);
        assign ch_w16[k] = ch_ack[k] && (role_k == ROLE_CS16);
        assign ch_av[k]  = ch_sel[k] && opt_k.avec && (opt_k.space == SP_CPU);

        AST_ROLE_QUIET: assert property (@(posedge clk) disable iff (rst)
            !role_k[1] && $stable(cfg_role) |=> cs_n[k]); // R2

        AST_LANE_OFF: assert property (@(posedge clk) disable iff (rst)
            (opt_k.lanes == 2'b00) && $stable(cfg_opt) |=> cs_n[k]); // R2

        AST_EXT_SILENT: assert property (@(posedge clk) disable iff (rst)
            (opt_k.wcode == WAIT_EXT) |-> !ch_w8[k] && !ch_w16[k]); // R11
    end

    assign ack8  = |ch_w8;
    assign ack16 = |ch_w16;
    assign avec  = |ch_av;

    AST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !as_i && !ds_i |=> (&cs_n) && !ack8 && !ack16); // R7

    AST_AVEC_CPU: assert property (@(posedge clk) disable iff (rst)
        avec |-> $past(cyc_space) == 2'd0); // R13

endmodule

// File: tb/csgen_top_test.sv
module csgen_top_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [23:0] addr = '0;
    logic [1:0]  cyc_space = '0;
    logic rd = 1'b1, lane_lo = 1'b0, lane_hi = 1'b0, as_i = 1'b0, ds_i = 1'b0;
    logic [2:0]  irq_lvl = '0;
    logic [N*16-1:0] cfg_base, cfg_opt;
    logic [N*2-1:0]  cfg_role;
    logic [N-1:0] cs_n;
    logic ack8, ack16, avec;

    logic [15:0] base_r [N];
    logic [15:0] opt_r  [N];
    logic [1:0]  role_r [N];

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "R8";

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            cfg_base[k*16 +: 16] = base_r[k];
            cfg_opt[k*16 +: 16]  = opt_r[k];
            cfg_role[k*2 +: 2]   = role_r[k];
        end
    end

    csgen_top #(.NUM_CS(N)) uut (
        .clk(clk), .rst(rst), .addr(addr), .cyc_space(cyc_space), .rd(rd),
        .lane_lo(lane_lo), .lane_hi(lane_hi), .irq_lvl(irq_lvl),
        .as_i(as_i), .ds_i(ds_i), .cfg_base(cfg_base), .cfg_opt(cfg_opt),
        .cfg_role(cfg_role), .cs_n(cs_n), .ack8(ack8), .ack16(ack16), .avec(avec)
    );

    // ---------------- reference model ----------------
    int msel [N];
    int mcnt [N];

    function automatic int region_bytes(input int code);
        case (code)
            0: return 2048;       1: return 8192;       2: return 16384;
            3: return 65536;      4: return 131072;     5: return 262144;
            6: return 524288;     default: return 1048576;
        endcase
    endfunction

    function automatic bit ref_hit(input int k);
        int sz, start, a;
        int lanes, dirf, spf, iplf, wantsp;
        bit ok;
        sz    = region_bytes(int'(base_r[k][2:0]));
        start = int'(base_r[k][15:3]) * 2048;
        a     = int'(addr);
        lanes = int'(opt_r[k][14:13]);
        dirf  = int'(opt_r[k][12:11]);
        spf   = int'(opt_r[k][5:4]);
        iplf  = int'(opt_r[k][3:1]);
        wantsp = int'(cyc_space);
        ok = (role_r[k] >= 2);
        ok &= (a / sz) == (start / sz);
        ok &= (lanes == 3) ? (lane_lo || lane_hi) :
              (lanes == 1) ? lane_lo : (lanes == 2) ? lane_hi : 1'b0;
        ok &= rd ? (dirf == 1 || dirf == 3) : (dirf == 2 || dirf == 3);
        ok &= (spf == 0) ? (wantsp == 0) : (spf == 1) ? (wantsp == 1) :
              (spf == 2) ? (wantsp == 2) : (wantsp == 1 || wantsp == 2);
        if (wantsp == 0) ok &= (iplf == 0) || (iplf == int'(irq_lvl));
        ok &= opt_r[k][10] ? ds_i : as_i;
        return ok;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (rst || !ref_hit(k)) begin
                msel[k] = 0; mcnt[k] = 0;
            end else begin
                if (msel[k] == 0) mcnt[k] = 0;
                else if (mcnt[k] < 15) mcnt[k] = mcnt[k] + 1;
                msel[k] = 1;
            end
        end
    end

    function automatic bit exp_ack(input int k);
        int w;
        w = int'(opt_r[k][9:6]);
        if (msel[k] == 0) return 1'b0;
        if (w == 14) return 1'b1;
        if (w == 15) return 1'b0;
        return mcnt[k] >= w + 1;
    endfunction

    task automatic cmp(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", cur_req, what, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [N-1:0] e_cs;
        bit e8, e16, eav;
        e8 = 0; e16 = 0; eav = 0;
        for (int k = 0; k < N; k++) begin
            e_cs[k] = !(msel[k] == 1 && (!opt_r[k][15] || mcnt[k] == 0));
            if (exp_ack(k) && role_r[k] == 2'b10) e8 = 1;
            if (exp_ack(k) && role_r[k] == 2'b11) e16 = 1;
            if (msel[k] == 1 && opt_r[k][0] && opt_r[k][5:4] == 2'b00) eav = 1;
        end
        cmp("cs_n", int'(cs_n), int'(e_cs));
        cmp("ack8", int'(ack8), int'(e8));
        cmp("ack16", int'(ack16), int'(e16));
        cmp("avec", int'(avec), int'(eav));
    end

    // ---------------- stimulus ----------------
    function automatic logic [15:0] mk_opt(input bit pulse, input int lanes, input int dirf,
        input bit on_ds, input int w, input int sp, input int ipl, input bit av);
        return {pulse, 2'(lanes), 2'(dirf), on_ds, 4'(w), 2'(sp), 3'(ipl), av};
    endfunction

    function automatic logic [15:0] mk_base(input logic [23:0] a, input int code);
        return {a[23:11], 3'(code)};
    endfunction

    task automatic bus_cycle(input logic [23:0] a, input int sp, input bit r,
                             input bit lo, input bit hi, input int lvl, input int len);
        @(negedge clk);
        addr = a; cyc_space = 2'(sp); rd = r; lane_lo = lo; lane_hi = hi;
        irq_lvl = 3'(lvl); as_i = 1'b1; ds_i = 1'b0;
        @(negedge clk);
        ds_i = 1'b1;
        repeat (len) @(negedge clk);
        as_i = 1'b0; ds_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic reset_cfg();
        base_r[0] = mk_base(24'h100000, 0); opt_r[0] = mk_opt(0, 3, 3, 0, 2, 3, 0, 0);  role_r[0] = 2'b11;
        base_r[1] = mk_base(24'h200000, 7); opt_r[1] = mk_opt(0, 1, 1, 1, 14, 2, 0, 0); role_r[1] = 2'b10;
        base_r[2] = mk_base(24'h040000, 3); opt_r[2] = mk_opt(0, 2, 2, 0, 15, 1, 0, 0); role_r[2] = 2'b11;
        base_r[3] = mk_base(24'hFFF800, 0); opt_r[3] = mk_opt(0, 3, 3, 0, 0, 0, 5, 1);  role_r[3] = 2'b10;
    endtask

    initial begin
        reset_cfg();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";  // address matching and size codes
        bus_cycle(24'h100000, 1, 1, 1, 1, 0, 5);
        bus_cycle(24'h1007FF, 2, 0, 1, 0, 0, 4);
        bus_cycle(24'h100800, 1, 1, 1, 1, 0, 4);
        for (int sz = 0; sz < 8; sz++) begin
            base_r[0] = mk_base(24'h100000, sz);
            bus_cycle(24'(32'h100000 + region_bytes(sz) - 1), 1, 1, 1, 1, 0, 3);
            bus_cycle(24'(32'h100000 + region_bytes(sz)), 1, 1, 1, 1, 0, 3);
        end
        reset_cfg();

        cur_req = "R2";  // pin role and disabled lanes
        role_r[0] = 2'b00; bus_cycle(24'h100010, 1, 1, 1, 1, 0, 4);
        role_r[0] = 2'b01; bus_cycle(24'h100010, 1, 1, 1, 1, 0, 4);
        role_r[0] = 2'b11; opt_r[0][14:13] = 2'b00; bus_cycle(24'h100010, 1, 1, 1, 1, 0, 4);
        reset_cfg();

        cur_req = "R3";  // byte lanes
        bus_cycle(24'h234000, 2, 1, 0, 1, 0, 3);
        bus_cycle(24'h234000, 2, 1, 1, 0, 0, 3);
        bus_cycle(24'h040100, 1, 0, 1, 0, 0, 3);
        bus_cycle(24'h040100, 1, 0, 0, 1, 0, 3);

        cur_req = "R4";  // direction
        bus_cycle(24'h234000, 2, 0, 1, 1, 0, 3);
        bus_cycle(24'h040100, 1, 1, 1, 1, 0, 3);
        opt_r[0][12:11] = 2'b00; bus_cycle(24'h100000, 1, 1, 1, 1, 0, 3);
        reset_cfg();

        cur_req = "R5";  // address space
        bus_cycle(24'h234000, 1, 1, 1, 0, 0, 3);
        bus_cycle(24'h040100, 2, 0, 0, 1, 0, 3);
        bus_cycle(24'h100000, 0, 1, 1, 1, 0, 3);
        bus_cycle(24'h100000, 3, 1, 1, 1, 0, 3);

        cur_req = "R6";  // interrupt level in CPU space
        bus_cycle(24'hFFF8F0, 0, 1, 1, 1, 5, 3);
        bus_cycle(24'hFFF8F0, 0, 1, 1, 1, 3, 3);
        opt_r[3][3:1] = 3'd0; bus_cycle(24'hFFF8F0, 0, 1, 1, 1, 3, 3);
        reset_cfg();

        cur_req = "R7";  // strobe selection
        opt_r[0][10] = 1'b1; bus_cycle(24'h100020, 1, 1, 1, 1, 0, 6);
        reset_cfg();

        cur_req = "R9";  // counted wait states
        for (int w = 0; w < 14; w++) begin
            opt_r[0][9:6] = 4'(w);
            bus_cycle(24'h100040, 2, 1, 1, 1, 0, 17);
        end
        reset_cfg();

        cur_req = "R10"; bus_cycle(24'h2FFFFE, 2, 1, 1, 0, 0, 4);
        cur_req = "R11"; bus_cycle(24'h04FFFE, 1, 0, 0, 1, 0, 8);
        cur_req = "R12"; opt_r[1][9:6] = 4'd1; bus_cycle(24'h200000, 2, 1, 1, 1, 0, 5);
        role_r[1] = 2'b11; bus_cycle(24'h200000, 2, 1, 1, 1, 0, 5);
        reset_cfg();
        cur_req = "R13"; bus_cycle(24'hFFF800, 0, 1, 1, 1, 5, 4);
        opt_r[3][0] = 1'b0; bus_cycle(24'hFFF800, 0, 1, 1, 1, 5, 4);
        reset_cfg();

        cur_req = "R14"; opt_r[0][15] = 1'b1; opt_r[0][9:6] = 4'd3;
        bus_cycle(24'h100000, 1, 1, 1, 1, 0, 8);
        reset_cfg();

        cur_req = "R1";  // mixed traffic around all regions
        for (int i = 0; i < 300; i++) begin
            logic [23:0] pick [4];
            pick[0] = 24'h100000; pick[1] = 24'h200000; pick[2] = 24'h040000; pick[3] = 24'hFFF800;
            bus_cycle(pick[$urandom_range(0, 3)] ^ 24'($urandom_range(0, 32'h1FFF)),
                      int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      int'($urandom_range(0, 7)), int'($urandom_range(1, 6)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule